// File: doc/BRIEF.md
# Shared-Vector Pin Edge Interrupt Latch

This block raises one interrupt request for a group of general-purpose pins that share a single interrupt vector. A pin takes part only when it is configured as an input and its interrupt option is set. The pins that take part are merged into one level, and that level is watched for the edge that software has chosen. When that edge arrives, a pending latch is set, and the latch drives the request line.

The latch stays set until the CPU acknowledges the vector fetch. It is also cleared when software writes the sensitivity setting, which gives software a way to throw away an unwanted pending request. The merge is an AND, so a pin held low hides edges on every other pin of the group.

Top module: `extint_group`

## Requirements
- R1: A pin takes part in the group only when its direction bit is 0 (input) and its option bit is 1. A pin that is an output, or that has its option bit at 0, has no effect on the request.
- R2: The merged level is the AND of all pins that take part, with every other pin counted as high. While one taking-part pin is low, edges on the other pins create no request.
- R3: The sensitivity bit selects the edge. Value 0 selects a falling edge of the merged level and value 1 selects a rising edge. The edge is compared against the merged level sampled on the previous clock. It is judged by the setting held before any write in the same cycle.
- R4: A detected edge makes `irq_req` high on the next rising clock edge. `irq_req` then stays high until it is cleared.
- R5: When `vec_ack` is high in a cycle with no detected edge, `irq_req` is low after the next clock.
- R6: A pulse on `sens_wr` loads `sens_wdata` into the sensitivity bit, which is visible on `sens_rd` after the next clock. The pulse also clears a pending request, even when the written value equals the old one.
- R7: When a clear (acknowledge or sensitivity write) and a detected edge fall in the same cycle, the edge wins and `irq_req` is high after the clock.
- R8: Reset gives `irq_req` = 0 and `sens_rd` = 0 (falling). It also sets the stored merged level to high, so that no edge is seen on the first cycle while all pins are high.
- R9: When no pin takes part, the merged level is high, and pin activity never sets a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | NUM_PINS | Level on each pin |
| pin_dir | input | NUM_PINS | Direction per pin: 0 input, 1 output |
| pin_opt | input | NUM_PINS | Interrupt option per pin: 1 enables |
| sens_wr | input | 1 | Write strobe for the sensitivity bit |
| sens_wdata | input | 1 | New sensitivity: 0 falling, 1 rising |
| vec_ack | input | 1 | Vector-fetch acknowledge, clears pending |
| irq_req | output | 1 | Pending interrupt request |
| sens_rd | output | 1 | Current sensitivity bit |

## Verification
The assertions check on every cycle that the latch follows its update rules:
- a detected edge always sets it;
- it holds while there is no clear;
- an acknowledge or a write without an edge always empties it;
- it only rises after an edge;
- the sensitivity bit changes only on a write.

Which pin patterns count as an edge can only be shown by the bench scenarios. These cover the qualification of pins, masking by a low pin, edge polarity judged against the setting held before a same-cycle write, and the edge-beats-clear ordering.

// File: rtl/extint_group_pkg.sv
package extint_group_pkg;

    typedef enum logic {
        SENS_FALL = 1'b0,
        SENS_RISE = 1'b1
    } sens_e;

    typedef struct packed {
        logic merged;
    } edge_state_t;

    typedef struct packed {
        sens_e sens;
        logic  pend;
    } latch_state_t;

endpackage

// File: rtl/extint_group_qual.sv
module extint_group_qual #(
    parameter int NUM_PINS = 4
) (
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] pin_dir,
    input  logic [NUM_PINS-1:0] pin_opt,
    output logic                merged
);
    logic [NUM_PINS-1:0] eff;

    // A pin outside the group reads as high, so it is neutral in the AND.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign eff[i] = (!pin_dir[i] && pin_opt[i]) ? pin_lvl[i] : 1'b1;
    end

    assign merged = &eff;
endmodule

// File: rtl/extint_group_edge.sv
module extint_group_edge
    import extint_group_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  merged_now,
    input  sens_e sens,
    output logic  edge_hit
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.merged = merged_now;
        // Compare against last cycle's stored level.
        if (sens == SENS_RISE) begin
            edge_hit = !st_q.merged && merged_now;
        end else begin
            edge_hit = st_q.merged && !merged_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.merged <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/extint_group_latch.sv
module extint_group_latch
    import extint_group_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  edge_hit,
    input  logic  sens_wr,
    input  logic  sens_wdata,
    input  logic  vec_ack,
    output logic  pend,
    output sens_e sens
);
    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sens_wr) begin
            st_d.sens = sens_e'(sens_wdata);
        end
        if (sens_wr || vec_ack) begin
            st_d.pend = 1'b0;
        end
        // Set has priority over clear.
        if (edge_hit) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sens <= SENS_FALL;
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
    assign sens = st_q.sens;
endmodule

// File: rtl/extint_group.sv
module extint_group
    import extint_group_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] pin_dir,
    input  logic [NUM_PINS-1:0] pin_opt,
    input  logic                sens_wr,
    input  logic                sens_wdata,
    input  logic                vec_ack,
    output logic                irq_req,
    output logic                sens_rd
);
    logic  merged_now;
    logic  edge_hit;
    sens_e sens;

    extint_group_qual #(.NUM_PINS(NUM_PINS)) u_qual (
        .pin_lvl (pin_lvl),
        .pin_dir (pin_dir),
        .pin_opt (pin_opt),
        .merged  (merged_now)
    );

    extint_group_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .merged_now (merged_now),
        .sens       (sens),
        .edge_hit   (edge_hit)
    );

    extint_group_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_hit   (edge_hit),
        .sens_wr    (sens_wr),
        .sens_wdata (sens_wdata),
        .vec_ack    (vec_ack),
        .pend       (irq_req),
        .sens       (sens)
    );

    assign sens_rd = sens;
endmodule

// File: rtl/extint_group_chk.sv
module extint_group_chk (
    input logic clk,
    input logic rst_n,
    input logic edge_hit,
    input logic sens_wr,
    input logic vec_ack,
    input logic irq_req,
    input logic sens_rd
);
    p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> irq_req);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !vec_ack && !sens_wr) |=> irq_req);

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && !edge_hit) |=> !irq_req);

    p_wr_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sens_wr && !edge_hit) |=> !irq_req);

    p_sens_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sens_wr |=> $stable(sens_rd));

    p_rise_needs_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && !edge_hit) |=> !irq_req);
endmodule

bind extint_group extint_group_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_hit (edge_hit),
    .sens_wr  (sens_wr),
    .vec_ack  (vec_ack),
    .irq_req  (irq_req),
    .sens_rd  (sens_rd)
);

// File: tb/extint_group_bench.sv
module extint_group_bench;
    localparam int N     = 4;
    localparam int NVEC  = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_lvl = '1, pin_dir = '0, pin_opt = '1;
    logic         sens_wr = 1'b0, sens_wdata = 1'b0, vec_ack = 1'b0;
    logic         irq_req, sens_rd;
    int           n_cmp = 0, n_bad = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    extint_group #(.NUM_PINS(N)) u_extint_group (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_dir(pin_dir),
        .pin_opt(pin_opt), .sens_wr(sens_wr), .sens_wdata(sens_wdata),
        .vec_ack(vec_ack), .irq_req(irq_req), .sens_rd(sens_rd)
    );

    // {lvl, dir, opt, wr, wdata, ack, expected irq}
    localparam logic [15:0] TBL [NVEC] = '{
        {4'hF, 4'h0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 idle high
        {4'hE, 4'h0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 R4 falling sets
        {4'hE, 4'h0, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 ack clears
        {4'hF, 4'h0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 rise ignored
        {4'hE, 4'h0, 4'hE, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 option off
        {4'h0, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 R9 all outputs
        {4'hF, 4'h0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'h7, 4'h0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 pin3 falls
        {4'h7, 4'h0, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 write clears
        {4'h3, 4'h0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 masked
        {4'hB, 4'h0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 masked rise
        {4'hF, 4'h0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 rising sets
        {4'h7, 4'h0, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 ack, fall ignored
        {4'hF, 4'h0, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 edge beats ack
        {4'h7, 4'h0, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 old setting used
        {4'hF, 4'h0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 rise now ignored
        {4'h7, 4'h0, 4'hF, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 edge beats write
        {4'h7, 4'h0, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0}  // R6 same-value write
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle();
        sens_wr = 1'b0; vec_ack = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8 irq at reset", irq_req, 1'b0);
        check("R8 sens at reset", sens_rd, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R8 no edge after reset", irq_req, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {pin_lvl, pin_dir, pin_opt, sens_wr, sens_wdata, vec_ack} = TBL[i][15:1];
            @(posedge clk); #1;
            check($sformatf("vector %0d", i), irq_req, TBL[i][0]);
        end
        @(negedge clk); idle();
        check("R6 sens readback after writes", sens_rd, 1'b0);

        // R6: write to rising is visible one clock later.
        @(negedge clk); sens_wr = 1'b1; sens_wdata = 1'b1;
        @(posedge clk); #1;
        check("R6 sens loaded", sens_rd, 1'b1);
        @(negedge clk); idle(); pin_lvl = 4'hF;
        @(posedge clk); #1;
        check("R3 rising after write", irq_req, 1'b1);

        // R4: pending holds across many quiet cycles.
        repeat (5) @(posedge clk);
        #1;
        check("R4 hold", irq_req, 1'b1);

        // R8: reset while pending.
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R8 async reset clears irq", irq_req, 1'b0);
        check("R8 async reset sens", sens_rd, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R9: no pin qualified, toggling does nothing.
        @(negedge clk); pin_opt = 4'h0; pin_lvl = 4'h0;
        @(posedge clk); #1;
        check("R9 no member", irq_req, 1'b0);
        @(negedge clk); pin_lvl = 4'hF;
        @(negedge clk); pin_lvl = 4'h0;
        @(posedge clk); #1;
        check("R9 no member toggle", irq_req, 1'b0);

        // R1: output-mode pin ignored even with option set.
        @(negedge clk); pin_opt = 4'hF; pin_dir = 4'h2; pin_lvl = 4'hF;
        @(negedge clk); pin_lvl = 4'hD;
        @(posedge clk); #1;
        check("R1 output pin ignored", irq_req, 1'b0);
        @(negedge clk); pin_lvl = 4'hC;
        @(posedge clk); #1;
        check("R1 input pin counted", irq_req, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule